// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block is a hardware controller that erases flash memory one block at a time. It drives four control strobes toward a flash array: a global write-enable, an erase-setup level, the erase pulse and an erase-verify level. It also drives a one-hot block select, a dummy-write strobe and a read strobe with a word address. All minimum gaps between strobe edges come from cycle counts that are sampled when an operation starts. No pre-programming pass is made before erasing.

After each erase pulse the block walks every word of the selected block. For each word it issues a dummy write of 0xFF to the address, waits, and then reads a 16-bit word. If any word is not all ones, the block leaves verify and fires another erase pulse. The number of pulses per block is capped, and reaching the cap ends the whole operation with a fail status. Blocks named in the start mask are handled from the lowest index to the highest. One `done` pulse closes the operation. It carries a pass flag and the index of the failing block.

States: IDLE, WEN_WAIT, SETUP, ERASE, HOLD, RECOVER, VFY_ENTER, DUMMY, SETTLE, READ, VFY_EXIT, DONE. Transitions:
- IDLE→WEN_WAIT: start with a non-empty mask.
- IDLE→DONE: start with an empty mask.
- WEN_WAIT→SETUP, SETUP→ERASE, ERASE→HOLD, HOLD→RECOVER, RECOVER→VFY_ENTER, VFY_ENTER→DUMMY and SETTLE→READ: each when its wait timer expires.
- DUMMY→SETTLE: always, after one cycle.
- READ→DUMMY: the word is erased and is not the last one.
- READ→VFY_EXIT: the last word is erased, or the word is not erased and the pulse cap is reached.
- READ→SETUP: the word is not erased and the cap is not reached (re-erase).
- VFY_EXIT→SETUP: the timer expires and another block is pending.
- VFY_EXIT→DONE: the timer expires and no block is pending, or the block failed.
- DONE→IDLE: always.

Top module: `blk_erase_seq`

## Requirements
- R1: `fl_wen` rises in the cycle after a start that is accepted. The select bit of the first block rises exactly `dly_en2sel`+1 cycles after `fl_wen` rises. `fl_blk_sel` is one-hot or zero, and it is non-zero only while `fl_wen` is high.
- R2: `fl_setup` rises in the same cycle as the first select of each operation. `fl_erase` rises exactly `dly_setup`+1 cycles after every rise of `fl_setup`. `fl_erase` is high only while `fl_setup` is high and a block is selected.
- R3: Each erase pulse stays high for exactly max(`pulse_len`,1) cycles and never longer.
- R4: `fl_setup` falls exactly `dly_hold`+1 cycles after `fl_erase` falls.
- R5: `fl_verify` rises exactly `dly_recover`+1 cycles after `fl_setup` falls, and never while `fl_setup` is high. The first dummy write after `fl_verify` rises comes `dly_enter_vfy`+1 cycles later, at word address 0. `fl_wdata` always carries 0xFF.
- R6: `fl_rd` rises exactly `dly_settle`+2 cycles after a `fl_dwr` rise, at the same address. Dummy writes and reads occur only while `fl_verify` is high, and never in the same cycle.
- R7: A word counts as erased only when `fl_rdata` equals 0xFFFF. After an erased word that is not the last, the dummy write for the next address comes in the next cycle. After a word that is not erased, `fl_verify` drops in the next cycle and `fl_setup` rises in the same cycle, unless R8 applies. The walk restarts at address 0 after every pulse.
- R8: A block receives at most max(`max_pulses`,1) erase pulses. A word that is not erased when the cap is reached ends the operation. `pass` is then 0, `fail_blk` holds that block's index, and no further block is selected.
- R9: After a pass or a fail, `fl_verify` falls. Exactly `dly_exit`+1 cycles later, either `fl_setup` rises for the next block or `fl_wen` falls.
- R10: Masked blocks are erased in ascending index order. A block whose mask bit is 0 is never selected.
- R11: After reset, `busy`, `done`, `pass` and all strobes are 0. `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse with `busy` low. A start while busy is ignored.
- R12: A start with an all-zero mask gives `done` with `pass`=1 in the next cycle, and no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in IDLE |
| blk_mask | input | NUM_BLK | Blocks to erase, sampled with start |
| dly_en2sel | input | DLY_W | Wait from write-enable to block select |
| dly_setup | input | DLY_W | Wait from erase-setup to erase pulse |
| pulse_len | input | DLY_W | Erase pulse length in cycles |
| dly_hold | input | DLY_W | Wait from erase fall to setup fall |
| dly_recover | input | DLY_W | Wait from setup fall to verify |
| dly_enter_vfy | input | DLY_W | Wait from verify entry to first dummy write |
| dly_settle | input | DLY_W | Wait after a dummy write before the read |
| dly_exit | input | DLY_W | Wait after leaving verify |
| max_pulses | input | RND_W | Erase pulse cap per block |
| fl_rdata | input | 16 | Verify read data from the array |
| fl_wen | output | 1 | Write-enable level |
| fl_blk_sel | output | NUM_BLK | One-hot block select |
| fl_setup | output | 1 | Erase-setup level |
| fl_erase | output | 1 | Erase pulse |
| fl_verify | output | 1 | Erase-verify level |
| fl_dwr | output | 1 | Dummy write strobe |
| fl_rd | output | 1 | Verify read strobe |
| fl_addr | output | ADDR_W | Word address within the block |
| fl_wdata | output | 8 | Dummy write data, 0xFF |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 when every block erased |
| fail_blk | output | IDX_W | Index of the block that failed |

## Verification
Every strobe comes straight from the state register, so each edge appears one clock after the transition that causes it. Each wait state lasts its programmed count plus one cycle; a read follows its dummy write by the settle count plus two. A monitor in the bench timestamps every strobe edge at the falling clock edge and compares the spacing with these exact figures from the requirements. The scenario tasks sample `busy` and `done` one time unit after the rising edge. They expect `done` in the cycle after an empty-mask start, and they check that `done` is gone one cycle later.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WEN_WAIT,
        ST_SETUP,
        ST_ERASE,
        ST_HOLD,
        ST_RECOVER,
        ST_VFY_ENTER,
        ST_DUMMY,
        ST_SETTLE,
        ST_READ,
        ST_VFY_EXIT,
        ST_DONE
    } seq_state_e;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;
    localparam logic [7:0]  DUMMY_BYTE  = 8'hFF;

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/erase_blk_picker.sv
module erase_blk_picker #(
    parameter int NUM_BLK = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BLK-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/blk_erase_seq.sv
module blk_erase_seq
    import erase_seq_pkg::*;
#(
    parameter  int NUM_BLK   = 4,
    parameter  int BLK_WORDS = 8,
    parameter  int DLY_W     = 8,
    parameter  int RND_W     = 4,
    localparam int IDX_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int ADDR_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NUM_BLK-1:0] blk_mask,
    input  logic [DLY_W-1:0]   dly_en2sel,
    input  logic [DLY_W-1:0]   dly_setup,
    input  logic [DLY_W-1:0]   pulse_len,
    input  logic [DLY_W-1:0]   dly_hold,
    input  logic [DLY_W-1:0]   dly_recover,
    input  logic [DLY_W-1:0]   dly_enter_vfy,
    input  logic [DLY_W-1:0]   dly_settle,
    input  logic [DLY_W-1:0]   dly_exit,
    input  logic [RND_W-1:0]   max_pulses,
    input  logic [15:0]        fl_rdata,
    output logic               fl_wen,
    output logic [NUM_BLK-1:0] fl_blk_sel,
    output logic               fl_setup,
    output logic               fl_erase,
    output logic               fl_verify,
    output logic               fl_dwr,
    output logic               fl_rd,
    output logic [ADDR_W-1:0]  fl_addr,
    output logic [7:0]         fl_wdata,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic [IDX_W-1:0]   fail_blk
);
    seq_state_e state_q, state_d;

    logic [DLY_W-1:0]   setup_q, zlen_q, hold_q, recov_q, enter_q, settle_q, exit_q;
    logic [RND_W-1:0]   cap_q, rounds_q;
    logic [NUM_BLK-1:0] pend_q, cur_oh, pick_src;
    logic [IDX_W-1:0]   cur_q, pick_idx, fail_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               pick_any, failed_q, pass_q;
    logic               t_load, t_exp;
    logic [DLY_W-1:0]   t_val, pulse_m1;
    logic               word_ok, addr_last, out_of_tries;

    assign cur_oh       = NUM_BLK'(1) << cur_q;
    assign pick_src     = (state_q == ST_IDLE) ? blk_mask : (pend_q & ~cur_oh);
    assign pulse_m1     = (zlen_q == '0) ? '0 : zlen_q - DLY_W'(1);
    assign word_ok      = (fl_rdata == ERASED_WORD);
    assign addr_last    = (addr_q == ADDR_W'(BLK_WORDS - 1));
    assign out_of_tries = (rounds_q >= cap_q);

    erase_wait_timer #(.W(DLY_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    erase_blk_picker #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) pick_i (
        .req (pick_src),
        .any (pick_any),
        .idx (pick_idx)
    );

    // next-state and wait-timer load
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                if (pick_any) begin
                    state_d = ST_WEN_WAIT; t_load = 1'b1; t_val = dly_en2sel;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_WEN_WAIT:  if (t_exp) begin state_d = ST_SETUP;     t_load = 1'b1; t_val = setup_q;  end
            ST_SETUP:     if (t_exp) begin state_d = ST_ERASE;     t_load = 1'b1; t_val = pulse_m1; end
            ST_ERASE:     if (t_exp) begin state_d = ST_HOLD;      t_load = 1'b1; t_val = hold_q;   end
            ST_HOLD:      if (t_exp) begin state_d = ST_RECOVER;   t_load = 1'b1; t_val = recov_q;  end
            ST_RECOVER:   if (t_exp) begin state_d = ST_VFY_ENTER; t_load = 1'b1; t_val = enter_q;  end
            ST_VFY_ENTER: if (t_exp) state_d = ST_DUMMY;
            ST_DUMMY: begin state_d = ST_SETTLE; t_load = 1'b1; t_val = settle_q; end
            ST_SETTLE:    if (t_exp) state_d = ST_READ;
            ST_READ: begin
                if (word_ok && !addr_last) begin
                    state_d = ST_DUMMY;
                end else if (word_ok || out_of_tries) begin
                    state_d = ST_VFY_EXIT; t_load = 1'b1; t_val = exit_q;
                end else begin
                    state_d = ST_SETUP; t_load = 1'b1; t_val = setup_q;
                end
            end
            ST_VFY_EXIT: if (t_exp) begin
                if (failed_q || !pick_any) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_SETUP; t_load = 1'b1; t_val = setup_q;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            setup_q  <= '0; zlen_q   <= '0; hold_q <= '0; recov_q <= '0;
            enter_q  <= '0; settle_q <= '0; exit_q <= '0; cap_q   <= '0;
            pend_q   <= '0; cur_q    <= '0; addr_q <= '0; rounds_q <= '0;
            failed_q <= 1'b0; pass_q <= 1'b0; fail_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                setup_q  <= dly_setup;     zlen_q   <= pulse_len;
                hold_q   <= dly_hold;      recov_q  <= dly_recover;
                enter_q  <= dly_enter_vfy; settle_q <= dly_settle;
                exit_q   <= dly_exit;      cap_q    <= max_pulses;
                pend_q   <= blk_mask;      cur_q    <= pick_idx;
                rounds_q <= '0;            failed_q <= 1'b0;
                pass_q   <= 1'b1;          fail_q   <= '0;
            end
            if (state_q == ST_SETUP && t_exp)
                rounds_q <= rounds_q + RND_W'(1);
            if (state_q == ST_RECOVER && t_exp)
                addr_q <= '0;
            if (state_q == ST_READ && word_ok && !addr_last)
                addr_q <= addr_q + ADDR_W'(1);
            if (state_q == ST_READ && !word_ok && out_of_tries) begin
                failed_q <= 1'b1;
                pass_q   <= 1'b0;
                fail_q   <= cur_q;
            end
            if (state_q == ST_VFY_EXIT && t_exp) begin
                pend_q   <= pend_q & ~cur_oh;
                cur_q    <= pick_idx;
                rounds_q <= '0;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        fl_wen     = 1'b0;
        fl_blk_sel = '0;
        fl_setup   = 1'b0;
        fl_erase   = 1'b0;
        fl_verify  = 1'b0;
        fl_dwr     = 1'b0;
        fl_rd      = 1'b0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_DONE:     begin busy = 1'b0; done = 1'b1; end
            ST_WEN_WAIT: fl_wen = 1'b1;
            ST_SETUP, ST_HOLD: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh; fl_setup = 1'b1;
            end
            ST_ERASE: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh; fl_setup = 1'b1; fl_erase = 1'b1;
            end
            ST_RECOVER, ST_VFY_EXIT: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh;
            end
            ST_VFY_ENTER, ST_SETTLE: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh; fl_verify = 1'b1;
            end
            ST_DUMMY: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh; fl_verify = 1'b1; fl_dwr = 1'b1;
            end
            ST_READ: begin
                fl_wen = 1'b1; fl_blk_sel = cur_oh; fl_verify = 1'b1; fl_rd = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign fl_addr  = addr_q;
    assign fl_wdata = DUMMY_BYTE;
    assign pass     = pass_q;
    assign fail_blk = fail_q;
endmodule

// File: rtl/blk_erase_seq_chk.sv
module blk_erase_seq_chk #(
    parameter int NUM_BLK = 4,
    parameter int DLY_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [DLY_W-1:0]   pulse_len,
    input logic               busy,
    input logic               done,
    input logic               fl_wen,
    input logic [NUM_BLK-1:0] fl_blk_sel,
    input logic               fl_setup,
    input logic               fl_erase,
    input logic               fl_verify,
    input logic               fl_dwr,
    input logic               fl_rd
);
    logic [DLY_W:0] er_run, z_eff;
    logic [DLY_W-1:0] z_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            er_run <= '0;
            z_lat  <= '0;
        end else begin
            if (start && !busy && !done)
                z_lat <= pulse_len;
            if (fl_erase) er_run <= er_run + 1'b1;
            else          er_run <= '0;
        end
    end

    assign z_eff = (z_lat == '0) ? (DLY_W+1)'(1) : {1'b0, z_lat};

    a_r1_sel_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        (|fl_blk_sel) |-> fl_wen);
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_blk_sel));
    a_r2_erase_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase |-> (fl_setup && (|fl_blk_sel)));
    a_r3_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fl_erase |-> (er_run < z_eff));
    a_r4_setup_outlasts_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_erase) |-> fl_setup);
    a_r5_verify_apart: assert property (@(posedge clk) disable iff (!rst_n)
        fl_verify |-> !fl_setup);
    a_r6_access_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_dwr || fl_rd) |-> fl_verify);
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_dwr && fl_rd));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !fl_wen));
endmodule

bind blk_erase_seq blk_erase_seq_chk #(.NUM_BLK(NUM_BLK), .DLY_W(DLY_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pulse_len  (pulse_len),
    .busy       (busy),
    .done       (done),
    .fl_wen     (fl_wen),
    .fl_blk_sel (fl_blk_sel),
    .fl_setup   (fl_setup),
    .fl_erase   (fl_erase),
    .fl_verify  (fl_verify),
    .fl_dwr     (fl_dwr),
    .fl_rd      (fl_rd)
);

// File: tb/blk_erase_seq_tb_top.sv
module blk_erase_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int WD = 8;
    localparam int DW = 8;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NB-1:0] blk_mask = '0;
    logic [DW-1:0] c_x = '0, c_y = '0, c_z = '0, c_a = '0, c_b = '0, c_g = '0, c_e = '0, c_h = '0;
    logic [RW-1:0] c_n = '0;
    logic [15:0] fl_rdata;
    logic fl_wen, fl_setup, fl_erase, fl_verify, fl_dwr, fl_rd, busy, done, pass;
    logic [NB-1:0] fl_blk_sel;
    logic [2:0] fl_addr;
    logic [7:0] fl_wdata;
    logic [1:0] fail_blk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int clk_cnt = 0;

    int need [NB][WD];
    int pulses [NB];
    int order [8];
    int ord_n = 0;
    int wen_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_erase_seq #(.NUM_BLK(NB), .BLK_WORDS(WD), .DLY_W(DW), .RND_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask),
        .dly_en2sel(c_x), .dly_setup(c_y), .pulse_len(c_z), .dly_hold(c_a),
        .dly_recover(c_b), .dly_enter_vfy(c_g), .dly_settle(c_e), .dly_exit(c_h),
        .max_pulses(c_n), .fl_rdata(fl_rdata), .fl_wen(fl_wen), .fl_blk_sel(fl_blk_sel),
        .fl_setup(fl_setup), .fl_erase(fl_erase), .fl_verify(fl_verify), .fl_dwr(fl_dwr),
        .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .busy(busy), .done(done),
        .pass(pass), .fail_blk(fail_blk)
    );

    function automatic int sel_idx(input logic [NB-1:0] s);
        for (int i = 0; i < NB; i++) if (s[i]) return i;
        return 0;
    endfunction

    // array stub: a word reads all ones once its pulse budget is used up
    always_comb fl_rdata = (need[sel_idx(fl_blk_sel)][fl_addr] == 0) ? 16'hFFFF : 16'hFFFE;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // strobe timing monitor, sampled on the falling edge
    logic p_wen = 0, p_setup = 0, p_erase = 0, p_verify = 0, p_dwr = 0, p_rd = 0;
    logic [NB-1:0] p_sel = '0;
    int t_wen, t_su_r, t_su_f, t_er_r, t_er_f, t_v_r, t_v_f, t_dwr, t_rd;
    int dwr_addr, rd_addr;
    bit first_sel, first_dwr, vf_valid, last_bad, rd_pend;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rd_pend && cyc == t_rd + 1) begin
                rd_pend = 0;
                if (last_bad) check_eq("R7 verify drops after bad word", int'(fl_verify), 0);
                else if (rd_addr != WD - 1) check_eq("R7 next dummy after good word", int'(fl_dwr), 1);
                else check_eq("R9 verify drops after last word", int'(fl_verify), 0);
            end
            if (fl_wen && !p_wen) begin
                t_wen = cyc; first_sel = 1; vf_valid = 0; wen_rises++;
            end
            if (!fl_wen && p_wen)
                check_eq("R9 wen falls after exit wait", cyc - t_v_f, int'(c_h) + 1);
            if (fl_blk_sel != '0 && fl_blk_sel != p_sel) begin
                check_eq("R1 select one-hot", $countones(fl_blk_sel), 1);
                check_eq("R1 select only with wen", int'(fl_wen), 1);
                if (ord_n < 8) order[ord_n] = sel_idx(fl_blk_sel);
                ord_n++;
                if (first_sel) begin
                    check_eq("R1 select after wen", cyc - t_wen, int'(c_x) + 1);
                    first_sel = 0;
                end
            end
            if (!fl_verify && p_verify) begin
                t_v_f = cyc;
            end
            if (fl_setup && !p_setup) begin
                t_su_r = cyc;
                if (p_verify && !fl_verify)
                    check_eq("R7 re-erase only after bad word", int'(last_bad), 1);
                else if (vf_valid)
                    check_eq("R9 next block after exit wait", cyc - t_v_f, int'(c_h) + 1);
                else
                    check_eq("R2 setup with first select", int'(p_sel == '0 && fl_blk_sel != '0), 1);
            end
            if (!fl_verify && p_verify) vf_valid = 1;
            if (fl_erase && !p_erase) begin
                check_eq("R2 erase after setup", cyc - t_su_r, int'(c_y) + 1);
                t_er_r = cyc;
                pulses[sel_idx(fl_blk_sel)]++;
                for (int w = 0; w < WD; w++)
                    if (need[sel_idx(fl_blk_sel)][w] > 0) need[sel_idx(fl_blk_sel)][w]--;
            end
            if (!fl_erase && p_erase) begin
                check_eq("R3 erase pulse length", cyc - t_er_r, (c_z == 0) ? 1 : int'(c_z));
                t_er_f = cyc;
            end
            if (!fl_setup && p_setup) begin
                check_eq("R4 setup fall after erase fall", cyc - t_er_f, int'(c_a) + 1);
                t_su_f = cyc;
            end
            if (fl_verify && !p_verify) begin
                check_eq("R5 verify after setup fall", cyc - t_su_f, int'(c_b) + 1);
                t_v_r = cyc; first_dwr = 1;
            end
            if (fl_dwr && !p_dwr) begin
                check_eq("R5 dummy data", int'(fl_wdata), 255);
                if (first_dwr) begin
                    check_eq("R5 first dummy delay", cyc - t_v_r, int'(c_g) + 1);
                    check_eq("R7 walk restarts at 0", int'(fl_addr), 0);
                    first_dwr = 0;
                end else begin
                    check_eq("R6 dummy address steps", int'(fl_addr), rd_addr + 1);
                end
                t_dwr = cyc; dwr_addr = int'(fl_addr);
            end
            if (fl_rd && !p_rd) begin
                check_eq("R6 read after dummy", cyc - t_dwr, int'(c_e) + 2);
                check_eq("R6 read address", int'(fl_addr), dwr_addr);
                t_rd = cyc; rd_addr = int'(fl_addr); rd_pend = 1;
                last_bad = (fl_rdata != 16'hFFFF);
            end
        end
        p_wen = fl_wen; p_setup = fl_setup; p_erase = fl_erase; p_verify = fl_verify;
        p_dwr = fl_dwr; p_rd = fl_rd; p_sel = fl_blk_sel;
    end

    always @(posedge clk) begin
        clk_cnt++;
        if (clk_cnt > 150000) begin
            errors++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", clk_cnt, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic prep(input int x, y, z, a, b, g, e, h, n);
        c_x = DW'(x); c_y = DW'(y); c_z = DW'(z); c_a = DW'(a);
        c_b = DW'(b); c_g = DW'(g); c_e = DW'(e); c_h = DW'(h); c_n = RW'(n);
        for (int i = 0; i < NB; i++) begin
            pulses[i] = 0;
            for (int w = 0; w < WD; w++) need[i][w] = 1;
        end
        ord_n = 0;
    endtask

    task automatic run_op(input logic [NB-1:0] mask, input bit poke);
        int n;
        @(posedge clk); #1;
        blk_mask = mask; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; blk_mask = '0;
        check_eq("R11 busy after start", int'(busy), 1);
        check_eq("R1 wen after start", int'(fl_wen), 1);
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk); #1;
            n++;
            if (poke && n == 30) begin start = 1'b1; blk_mask = 4'b1000; end
            else if (poke && n == 31) begin start = 1'b0; blk_mask = '0; end
        end
        check_eq("R11 done seen", int'(done), 1);
        check_eq("R11 busy low at done", int'(busy), 0);
        @(posedge clk); #1;
        check_eq("R11 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        check_eq("R11 reset busy", int'(busy), 0);
        check_eq("R11 reset done", int'(done), 0);
        check_eq("R11 reset pass", int'(pass), 0);
        check_eq("R11 reset wen", int'(fl_wen), 0);
        check_eq("R11 reset select", int'(fl_blk_sel), 0);
    endtask

    task automatic t_single;
        prep(3, 2, 5, 1, 2, 3, 1, 4, 3);
        run_op(4'b0100, 1'b0);
        check_eq("R8 single pass", int'(pass), 1);
        check_eq("R10 single pulses blk2", pulses[2], 1);
        check_eq("R10 single untouched blk0", pulses[0], 0);
        check_eq("R10 single order count", ord_n, 1);
    endtask

    task automatic t_multi;
        prep(0, 0, 0, 0, 0, 0, 0, 0, 4);
        need[1][5] = 3;
        run_op(4'b1011, 1'b0);
        check_eq("R8 multi pass", int'(pass), 1);
        check_eq("R7 multi re-erase blk1", pulses[1], 3);
        check_eq("R10 multi pulses blk0", pulses[0], 1);
        check_eq("R10 multi untouched blk2", pulses[2], 0);
        check_eq("R10 multi order count", ord_n, 3);
        check_eq("R10 multi order 0", order[0], 0);
        check_eq("R10 multi order 1", order[1], 1);
        check_eq("R10 multi order 2", order[2], 3);
    endtask

    task automatic t_fail;
        prep(2, 1, 3, 2, 1, 1, 2, 2, 2);
        need[1][7] = 5;
        run_op(4'b0110, 1'b1);
        check_eq("R8 fail flag", int'(pass), 0);
        check_eq("R8 fail index", int'(fail_blk), 1);
        check_eq("R8 pulse cap", pulses[1], 2);
        check_eq("R8 later block skipped", pulses[2], 0);
        check_eq("R11 start while busy ignored", pulses[3], 0);
        check_eq("R8 one block selected", ord_n, 1);
    endtask

    task automatic t_empty;
        int w0;
        prep(1, 1, 1, 1, 1, 1, 1, 1, 1);
        w0 = wen_rises;
        @(posedge clk); #1;
        start = 1'b1; blk_mask = '0;
        @(posedge clk); #1;
        start = 1'b0;
        check_eq("R12 done next cycle", int'(done), 1);
        check_eq("R12 pass", int'(pass), 1);
        @(posedge clk); #1;
        check_eq("R12 done one cycle", int'(done), 0);
        check_eq("R12 no wen", wen_rises - w0, 0);
    endtask

    initial begin
        prep(0, 0, 1, 0, 0, 0, 0, 0, 1);
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_single();
        t_multi();
        t_fail();
        t_empty();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule